// File: doc/BRIEF.md
# USB Endpoint Handshake Control Registers

This block keeps the control and status state for a USB device's default control endpoint (endpoint 0, with receive and transmit directions) and for the receive direction of endpoint 1. For every token that the serial interface engine reports, it chooses the handshake that the endpoint returns: ACK, NAK, STALL, or no reply at all. It also raises a transmit-go level that lets the engine send the packet staged in buffer memory.

A local processor reaches four byte-wide registers through a simple read/write port. Reads are combinational and writes take effect on the next clock edge. The engine drives single-cycle strobes: token arrivals with their type and data toggle, transmit completion, bus reset, clear-halt for endpoint 1, and its own stall requests. It also holds three direction-enable levels.

The halt bits are one-way from software. A write can only set them. Only protocol events clear them: a SETUP or a bus reset for endpoint 0, and a clear-halt command or a bus reset for endpoint 1. While a transmit is pending, OUT tokens on endpoint 0 get NAK. A SETUP on endpoint 0 is always accepted, even when the endpoint is halted.

Top module: `usb_ep_hs_ctrl`

## Requirements
- R1: After reset, all four registers read 0x00, `tx_go` is 0 and `hs_vld` is 0.
- R2: The read layout is as follows. At 0xAD, bits [3:0] hold the configuration. The endpoint 0 receive register is at 0xAF and the endpoint 1 receive register is at 0xB2. In both, bit 3 is the data toggle, bit 2 is the halt bit and bit 0 is the live direction-enable input. At 0xB1, the endpoint 0 transmit register has bit 4 as the transmit-pending bit, bit 2 as the halt bit and bit 0 as the enable input. Every other bit reads 0, and every other address reads 0x00.
- R3: `cfg_set_vld` loads `cfg_set_val` into the configuration field on the next edge. A processor write to 0xAD has no effect.
- R4: A halt bit is set on the next edge by a processor write with bit 2 = 1 to its register, or by its engine stall strobe. A write with bit 2 = 0 leaves the bit unchanged.
- R5: A SETUP token addressed to endpoint 0, or `bus_rst`, clears both endpoint 0 halt bits on the next edge. The clear wins over a set in the same cycle.
- R6: The endpoint 1 halt bit is cleared by `clr_halt_ep1` or `bus_rst`, with the clear winning over a same-cycle set. A SETUP to endpoint 0 leaves it unchanged.
- R7: A write to 0xB1 with bit 4 = 1 sets the transmit-pending bit, and `tx_go` follows it. `tx_done` clears the bit. When both happen in one cycle, the write wins. A write with bit 4 = 0 has no effect.
- R8: An OUT or SETUP token addressed to endpoint 0 or 1 loads `tok_dtog` into that endpoint's toggle bit on the next edge.
- R9: `hs_vld` is high exactly one cycle after `tok_vld`. Handshake codes are 0 = none, 1 = ACK, 2 = NAK and 3 = STALL. The token types are 0 = OUT, 1 = IN, 2 = SETUP, and 3 = unused. The code is none in these cases: the addressed direction is disabled, the endpoint number is above 1, the token is IN to endpoint 1, or the token type is 3. The decision uses register state from before the token's own updates.
- R10: An OUT to an enabled endpoint 0 gets STALL if its receive halt bit is set. Otherwise it gets NAK while a transmit is pending, and ACK in all other cases.
- R11: A SETUP to an enabled endpoint 0 gets ACK regardless of the halt and transmit-pending bits.
- R12: An IN to an enabled endpoint 0 gets STALL if the transmit halt bit is set, and ACK otherwise.
- R13: An OUT or SETUP to an enabled endpoint 1 gets STALL if its halt bit is set, and ACK otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 8 | Processor register address |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Processor read data (combinational) |
| tok_vld | input | 1 | Token received strobe |
| tok_ep | input | 4 | Endpoint number of the token |
| tok_pid | input | 2 | Token type (0 OUT, 1 IN, 2 SETUP) |
| tok_dtog | input | 1 | Data toggle of the token |
| tx_done | input | 1 | Endpoint 0 packet transmission completed |
| bus_rst | input | 1 | USB bus reset seen |
| clr_halt_ep1 | input | 1 | Clear-halt command for endpoint 1 |
| eng_stall_ep0_rx | input | 1 | Engine request to halt endpoint 0 receive |
| eng_stall_ep0_tx | input | 1 | Engine request to halt endpoint 0 transmit |
| eng_stall_ep1_rx | input | 1 | Engine request to halt endpoint 1 receive |
| ep0_rx_en | input | 1 | Endpoint 0 receive enabled |
| ep0_tx_en | input | 1 | Endpoint 0 transmit enabled |
| ep1_rx_en | input | 1 | Endpoint 1 receive enabled |
| cfg_set_vld | input | 1 | Host configuration load strobe |
| cfg_set_val | input | 4 | Configuration value from the host |
| hs_vld | output | 1 | Handshake decision valid |
| hs_code | output | 2 | Handshake code (0 none, 1 ACK, 2 NAK, 3 STALL) |
| tx_go | output | 1 | Transmit pending for endpoint 0 |

## Verification
The bench builds the block with its default parameters: a 4-bit endpoint field, a 4-bit configuration field and the default register addresses. The wide endpoint field lets random tokens reach endpoint numbers above 1, which exercises the no-reply path. The 4-bit configuration field lets host loads cover every value. Random processor traffic also hits unmapped addresses, so the zero-read rule is tested alongside the four mapped registers. Set, clear, token and write collisions in the same cycle happen both in directed steps and under random strobes.

// File: rtl/usb_ep_hs_pkg.sv
package usb_ep_hs_pkg;

    typedef enum logic [1:0] {
        PID_OUT   = 2'd0,
        PID_IN    = 2'd1,
        PID_SETUP = 2'd2
    } tok_pid_e;

    typedef enum logic [1:0] {
        HS_NONE  = 2'd0,
        HS_ACK   = 2'd1,
        HS_NAK   = 2'd2,
        HS_STALL = 2'd3
    } hs_code_e;

    typedef struct packed {
        logic stall;
        logic dtog;
    } rx_state_t;

    typedef struct packed {
        logic stall;
        logic pend;
    } tx_state_t;

    typedef struct packed {
        logic     vld;
        hs_code_e code;
    } hs_state_t;

endpackage

// File: rtl/ep_rx_ctl.sv
module ep_rx_ctl
    import usb_ep_hs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_stall,
    input  logic clr_stall,
    input  logic dtog_ld,
    input  logic dtog_in,
    output logic stall_q,
    output logic dtog_q
);

    rx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_stall) st_d.stall = 1'b1;
        if (clr_stall) st_d.stall = 1'b0;   // protocol clear has priority
        if (dtog_ld)   st_d.dtog  = dtog_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stall_q = st_q.stall;
    assign dtog_q  = st_q.dtog;

    // R5
    stall_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stall |=> !stall_q);

    // R4
    stall_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_stall && !clr_stall) |=> stall_q);

    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_stall && !clr_stall) |=> $stable(stall_q));

    // R8
    dtog_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dtog_ld |=> (dtog_q == $past(dtog_in)));

endmodule

// File: rtl/ep0_tx_ctl.sv
module ep0_tx_ctl
    import usb_ep_hs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_stall,
    input  logic clr_stall,
    input  logic pend_wr1,
    input  logic pend_done,
    output logic stall_q,
    output logic pend_q
);

    tx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_stall) st_d.stall = 1'b1;
        if (clr_stall) st_d.stall = 1'b0;
        if (pend_done) st_d.pend  = 1'b0;
        if (pend_wr1)  st_d.pend  = 1'b1;   // fresh request beats completion
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stall_q = st_q.stall;
    assign pend_q  = st_q.pend;

    // R5
    tx_stall_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stall |=> !stall_q);

    // R7
    tx_pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_wr1 |=> pend_q);

    // R7
    tx_pend_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_done && !pend_wr1) |=> !pend_q);

endmodule

// File: rtl/ep_hs_decide.sv
module ep_hs_decide
    import usb_ep_hs_pkg::*;
#(
    parameter int unsigned EP_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tok_vld,
    input  logic [EP_W-1:0] tok_ep,
    input  logic [1:0]      tok_pid,
    input  logic            en0_rx,
    input  logic            en0_tx,
    input  logic            en1_rx,
    input  logic            stall0_rx,
    input  logic            stall0_tx,
    input  logic            stall1_rx,
    input  logic            tx_pend,
    output logic            hs_vld,
    output logic [1:0]      hs_code
);

    hs_state_t hs_d, hs_q;
    logic      at_ep0, at_ep1;

    assign at_ep0 = (tok_ep == EP_W'(0));
    assign at_ep1 = (tok_ep == EP_W'(1));

    always_comb begin
        hs_d.vld  = tok_vld;
        hs_d.code = HS_NONE;
        if (tok_vld && at_ep0) begin
            case (tok_pid)
                PID_OUT: if (en0_rx)
                    hs_d.code = stall0_rx ? HS_STALL : (tx_pend ? HS_NAK : HS_ACK);
                PID_SETUP: if (en0_rx)
                    hs_d.code = HS_ACK;
                PID_IN: if (en0_tx)
                    hs_d.code = stall0_tx ? HS_STALL : HS_ACK;
                default: hs_d.code = HS_NONE;
            endcase
        end else if (tok_vld && at_ep1 && en1_rx &&
                     (tok_pid == PID_OUT || tok_pid == PID_SETUP)) begin
            hs_d.code = stall1_rx ? HS_STALL : HS_ACK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hs_q <= '{vld: 1'b0, code: HS_NONE};
        else        hs_q <= hs_d;
    end

    assign hs_vld  = hs_q.vld;
    assign hs_code = hs_q.code;

    // R9
    hs_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tok_vld |=> hs_vld);

    // R9
    hs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tok_vld |=> (!hs_vld && hs_code == 2'd0));

    // R11
    setup_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_vld && at_ep0 && tok_pid == 2'd2 && en0_rx) |=> (hs_code == 2'd1));

    // R9
    far_ep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_vld && !at_ep0 && !at_ep1) |=> (hs_code == 2'd0));

endmodule

// File: rtl/usb_ep_hs_ctrl.sv
module usb_ep_hs_ctrl
    import usb_ep_hs_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned EP_W       = 4,
    parameter int unsigned CFG_W      = 4,
    parameter logic [7:0]  CFG_ADDR   = 8'hAD,
    parameter logic [7:0]  EP0RX_ADDR = 8'hAF,
    parameter logic [7:0]  EP0TX_ADDR = 8'hB1,
    parameter logic [7:0]  EP1RX_ADDR = 8'hB2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              tok_vld,
    input  logic [EP_W-1:0]   tok_ep,
    input  logic [1:0]        tok_pid,
    input  logic              tok_dtog,
    input  logic              tx_done,
    input  logic              bus_rst,
    input  logic              clr_halt_ep1,
    input  logic              eng_stall_ep0_rx,
    input  logic              eng_stall_ep0_tx,
    input  logic              eng_stall_ep1_rx,
    input  logic              ep0_rx_en,
    input  logic              ep0_tx_en,
    input  logic              ep1_rx_en,
    input  logic              cfg_set_vld,
    input  logic [CFG_W-1:0]  cfg_set_val,
    output logic              hs_vld,
    output logic [1:0]        hs_code,
    output logic              tx_go
);

    localparam int unsigned NUM_RX    = 2;
    localparam int unsigned EN_BIT    = 0;
    localparam int unsigned STALL_BIT = 2;
    localparam int unsigned DTOG_BIT  = 3;
    localparam int unsigned TX_BIT    = 4;
    localparam logic [ADDR_W-1:0] RX_ADDR [NUM_RX] = '{ADDR_W'(EP0RX_ADDR), ADDR_W'(EP1RX_ADDR)};

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
    } cfg_state_t;

    cfg_state_t cs_d, cs_q;

    logic              setup_ep0, data_tok;
    logic [NUM_RX-1:0] rx_set, rx_clr, rx_ld, rx_stall, rx_dtog, rx_en;
    logic [NUM_RX-1:0] eng_rx_stall;
    logic [NUM_RX-1:0] rx_tok_ep;
    logic              tx_stall, tx_pend, wr_tx;
    logic              unused_wdata;

    assign unused_wdata = ^{cpu_wdata[DATA_W-1:TX_BIT+1], cpu_wdata[DTOG_BIT],
                            cpu_wdata[STALL_BIT-1:0]};

    // token classification shared by both receive endpoints
    assign setup_ep0    = tok_vld && (tok_ep == EP_W'(0)) && (tok_pid == PID_SETUP);
    assign data_tok     = tok_vld && (tok_pid == PID_OUT || tok_pid == PID_SETUP);
    assign rx_tok_ep    = {tok_ep == EP_W'(1), tok_ep == EP_W'(0)};
    assign eng_rx_stall = {eng_stall_ep1_rx, eng_stall_ep0_rx};
    assign rx_en        = {ep1_rx_en, ep0_rx_en};
    assign rx_clr       = {clr_halt_ep1 || bus_rst, setup_ep0 || bus_rst};

    for (genvar g = 0; g < NUM_RX; g++) begin : g_rx
        assign rx_set[g] = (cpu_wr && cpu_addr == RX_ADDR[g] && cpu_wdata[STALL_BIT])
                           || eng_rx_stall[g];
        assign rx_ld[g]  = data_tok && rx_tok_ep[g];

        ep_rx_ctl u_rx (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_stall(rx_set[g]),
            .clr_stall(rx_clr[g]),
            .dtog_ld  (rx_ld[g]),
            .dtog_in  (tok_dtog),
            .stall_q  (rx_stall[g]),
            .dtog_q   (rx_dtog[g])
        );
    end

    assign wr_tx = cpu_wr && (cpu_addr == ADDR_W'(EP0TX_ADDR));

    ep0_tx_ctl u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_stall((wr_tx && cpu_wdata[STALL_BIT]) || eng_stall_ep0_tx),
        .clr_stall(setup_ep0 || bus_rst),
        .pend_wr1 (wr_tx && cpu_wdata[TX_BIT]),
        .pend_done(tx_done),
        .stall_q  (tx_stall),
        .pend_q   (tx_pend)
    );

    ep_hs_decide #(.EP_W(EP_W)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .tok_vld  (tok_vld),
        .tok_ep   (tok_ep),
        .tok_pid  (tok_pid),
        .en0_rx   (ep0_rx_en),
        .en0_tx   (ep0_tx_en),
        .en1_rx   (ep1_rx_en),
        .stall0_rx(rx_stall[0]),
        .stall0_tx(tx_stall),
        .stall1_rx(rx_stall[1]),
        .tx_pend  (tx_pend),
        .hs_vld   (hs_vld),
        .hs_code  (hs_code)
    );

    // configuration number: host-loaded only
    always_comb begin
        cs_d = cs_q;
        if (cfg_set_vld) cs_d.cfg = cfg_set_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    // read multiplexer
    always_comb begin
        cpu_rdata = '0;
        if (cpu_addr == ADDR_W'(CFG_ADDR)) begin
            cpu_rdata[CFG_W-1:0] = cs_q.cfg;
        end else if (cpu_addr == ADDR_W'(EP0TX_ADDR)) begin
            cpu_rdata[TX_BIT]    = tx_pend;
            cpu_rdata[STALL_BIT] = tx_stall;
            cpu_rdata[EN_BIT]    = ep0_tx_en;
        end else begin
            for (int i = 0; i < NUM_RX; i++) begin
                if (cpu_addr == RX_ADDR[i]) begin
                    cpu_rdata[DTOG_BIT]  = rx_dtog[i];
                    cpu_rdata[STALL_BIT] = rx_stall[i];
                    cpu_rdata[EN_BIT]    = rx_en[i];
                end
            end
        end
    end

    assign tx_go = tx_pend;

    // R3
    cfg_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_set_vld |=> $stable(cs_q.cfg));

    // R6
    ep1_setup_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_ep0 && !clr_halt_ep1 && !bus_rst && rx_stall[1]) |=> rx_stall[1]);

    // R7
    tx_go_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_tx && cpu_wdata[TX_BIT]) |=> tx_go);

endmodule

// File: tb/test_usb_ep_hs_ctrl.sv
module test_usb_ep_hs_ctrl;

    localparam logic [7:0] A_CFG = 8'hAD, A_R0 = 8'hAF, A_T0 = 8'hB1, A_R1 = 8'hB2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cpu_addr = '0, cpu_wdata = '0, cpu_rdata;
    logic       cpu_wr = 0, tok_vld = 0, tok_dtog = 0, tx_done = 0, bus_rst = 0;
    logic [3:0] tok_ep = '0, cfg_set_val = '0;
    logic [1:0] tok_pid = '0, hs_code;
    logic       clr_halt_ep1 = 0, e_s0r = 0, e_s0t = 0, e_s1r = 0;
    logic       en0r = 0, en0t = 0, en1r = 0, cfg_set_vld = 0;
    logic       hs_vld, tx_go;

    int compared = 0, mismatched = 0;
    bit done = 0;

    // reference state
    logic [3:0] m_cfg = '0;
    logic m_s0r = 0, m_s0t = 0, m_s1r = 0, m_tx = 0, m_d0 = 0, m_d1 = 0, m_hsv = 0;
    logic [1:0] m_hsc = '0;

    always #5 clk = ~clk;

    usb_ep_hs_ctrl i_usb_ep_hs_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .tok_vld(tok_vld),
        .tok_ep(tok_ep), .tok_pid(tok_pid), .tok_dtog(tok_dtog), .tx_done(tx_done),
        .bus_rst(bus_rst), .clr_halt_ep1(clr_halt_ep1), .eng_stall_ep0_rx(e_s0r),
        .eng_stall_ep0_tx(e_s0t), .eng_stall_ep1_rx(e_s1r), .ep0_rx_en(en0r),
        .ep0_tx_en(en0t), .ep1_rx_en(en1r), .cfg_set_vld(cfg_set_vld),
        .cfg_set_val(cfg_set_val), .hs_vld(hs_vld), .hs_code(hs_code), .tx_go(tx_go)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd();
        logic [7:0] r = 8'h00;
        case (cpu_addr)
            A_CFG: r = {4'h0, m_cfg};
            A_R0:  r = {4'h0, m_d0, m_s0r, 1'b0, en0r};
            A_T0:  r = {3'b000, m_tx, 1'b0, m_s0t, 1'b0, en0t};
            A_R1:  r = {4'h0, m_d1, m_s1r, 1'b0, en1r};
            default: r = 8'h00;
        endcase
        return r;
    endfunction

    // one clock: compare read port, advance the reference, compare registered outputs
    task automatic cycle(input string tag);
        logic n_s0r, n_s0t, n_s1r, n_tx, n_d0, n_d1;
        logic [3:0] n_cfg;
        logic [1:0] n_hsc;
        bit setup0, wr_r0, wr_t0, wr_r1;
        #1;
        chk(tag, "rdata", cpu_rdata, exp_rd());
        setup0 = tok_vld && tok_ep == 0 && tok_pid == 2;
        wr_r0 = cpu_wr && cpu_addr == A_R0;
        wr_t0 = cpu_wr && cpu_addr == A_T0;
        wr_r1 = cpu_wr && cpu_addr == A_R1;
        n_s0r = (setup0 || bus_rst) ? 1'b0 : (m_s0r || (wr_r0 && cpu_wdata[2]) || e_s0r);
        n_s0t = (setup0 || bus_rst) ? 1'b0 : (m_s0t || (wr_t0 && cpu_wdata[2]) || e_s0t);
        n_s1r = (clr_halt_ep1 || bus_rst) ? 1'b0 : (m_s1r || (wr_r1 && cpu_wdata[2]) || e_s1r);
        if (wr_t0 && cpu_wdata[4]) n_tx = 1'b1;
        else if (tx_done)          n_tx = 1'b0;
        else                       n_tx = m_tx;
        n_d0 = (tok_vld && tok_ep == 0 && (tok_pid == 0 || tok_pid == 2)) ? tok_dtog : m_d0;
        n_d1 = (tok_vld && tok_ep == 1 && (tok_pid == 0 || tok_pid == 2)) ? tok_dtog : m_d1;
        n_cfg = cfg_set_vld ? cfg_set_val : m_cfg;
        n_hsc = 2'd0;
        if (tok_vld && tok_ep == 0) begin
            if (tok_pid == 0 && en0r)      n_hsc = m_s0r ? 2'd3 : (m_tx ? 2'd2 : 2'd1);
            else if (tok_pid == 2 && en0r) n_hsc = 2'd1;
            else if (tok_pid == 1 && en0t) n_hsc = m_s0t ? 2'd3 : 2'd1;
        end else if (tok_vld && tok_ep == 1 && (tok_pid == 0 || tok_pid == 2) && en1r) begin
            n_hsc = m_s1r ? 2'd3 : 2'd1;
        end
        @(posedge clk);
        m_s0r = n_s0r; m_s0t = n_s0t; m_s1r = n_s1r; m_tx = n_tx;
        m_d0 = n_d0; m_d1 = n_d1; m_cfg = n_cfg; m_hsv = tok_vld; m_hsc = n_hsc;
        @(negedge clk);
        chk(tag, "tx_go", tx_go, m_tx);
        chk(tag, "hs_vld", hs_vld, m_hsv);
        chk(tag, "hs_code", hs_code, m_hsc);
    endtask

    task automatic quiet();
        cpu_wr = 0; tok_vld = 0; tx_done = 0; bus_rst = 0; clr_halt_ep1 = 0;
        e_s0r = 0; e_s0t = 0; e_s1r = 0; cfg_set_vld = 0;
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        quiet(); cpu_addr = a; cycle(tag);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input string tag);
        quiet(); cpu_addr = a; cpu_wr = 1; cpu_wdata = d; cycle(tag);
    endtask

    task automatic tok(input int ep, input int pid, input bit dt, input string tag);
        quiet(); tok_vld = 1; tok_ep = 4'(ep); tok_pid = 2'(pid); tok_dtog = dt; cycle(tag);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            mismatched++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset values
        rd(A_CFG, "R1"); rd(A_R0, "R1"); rd(A_T0, "R1"); rd(A_R1, "R1");
        // R2 enables and unmapped addresses
        en0r = 1; en0t = 1; en1r = 1;
        rd(A_R0, "R2"); rd(A_T0, "R2"); rd(A_R1, "R2"); rd(8'h00, "R2"); rd(8'hB0, "R2");
        // R3 configuration
        quiet(); cfg_set_vld = 1; cfg_set_val = 4'hA; cpu_addr = A_CFG; cycle("R3");
        rd(A_CFG, "R3"); wr(A_CFG, 8'hFF, "R3"); rd(A_CFG, "R3");
        // R4 setting halt bits
        wr(A_R0, 8'h04, "R4"); rd(A_R0, "R4"); wr(A_R0, 8'h00, "R4"); rd(A_R0, "R4");
        quiet(); e_s0t = 1; cpu_addr = A_T0; cycle("R4"); rd(A_T0, "R4");
        // R10 / R12 halted responses, R11 SETUP still accepted, R5 clear
        tok(0, 0, 0, "R10"); tok(0, 1, 0, "R12"); rd(A_R0, "R10");
        tok(0, 2, 1, "R11"); rd(A_R0, "R5"); rd(A_T0, "R5");
        tok(0, 1, 0, "R12"); tok(0, 0, 0, "R10");
        // R5 clear beats same-cycle set
        quiet(); tok_vld = 1; tok_ep = 0; tok_pid = 2; cpu_wr = 1; cpu_addr = A_R0;
        cpu_wdata = 8'h04; e_s0t = 1; cycle("R5"); rd(A_R0, "R5"); rd(A_T0, "R5");
        // R7 transmit pending
        wr(A_T0, 8'h10, "R7"); rd(A_T0, "R7");
        tok(0, 0, 0, "R10"); tok(0, 2, 0, "R11");
        quiet(); cpu_wr = 1; cpu_addr = A_T0; cpu_wdata = 8'h10; tx_done = 1; cycle("R7");
        wr(A_T0, 8'h00, "R7"); rd(A_T0, "R7");
        quiet(); tx_done = 1; cycle("R7"); rd(A_T0, "R7"); tok(0, 0, 1, "R10");
        // R6 / R13 endpoint 1 halt
        wr(A_R1, 8'h04, "R6"); tok(1, 0, 1, "R13"); tok(1, 2, 0, "R13");
        tok(0, 2, 0, "R6"); rd(A_R1, "R6");
        quiet(); clr_halt_ep1 = 1; e_s1r = 1; cycle("R6"); rd(A_R1, "R6");
        tok(1, 0, 0, "R13");
        quiet(); e_s1r = 1; e_s0r = 1; e_s0t = 1; cycle("R6");
        quiet(); bus_rst = 1; cpu_addr = A_R1; cycle("R6"); rd(A_R0, "R5"); rd(A_T0, "R5");
        // R8 toggles
        tok(1, 0, 1, "R8"); rd(A_R1, "R8"); tok(0, 2, 1, "R8"); rd(A_R0, "R8");
        tok(0, 1, 0, "R8"); rd(A_R0, "R8"); tok(1, 2, 0, "R8"); rd(A_R1, "R8");
        // R9 no-reply cases
        en0r = 0; tok(0, 0, 0, "R9"); tok(0, 2, 0, "R9"); rd(A_R0, "R9");
        en0r = 1; tok(1, 1, 0, "R9"); tok(5, 0, 0, "R9"); tok(0, 3, 0, "R9");
        en0t = 0; tok(0, 1, 0, "R9"); en1r = 0; tok(1, 0, 0, "R9"); en0t = 1; en1r = 1;
        // random traffic against the reference
        for (int n = 0; n < 4000; n++) begin
            int sel;
            quiet();
            if (n % 16 == 0) begin
                en0r = ($urandom % 4) != 0; en0t = ($urandom % 4) != 0; en1r = ($urandom % 4) != 0;
            end
            sel = $urandom % 5;
            cpu_addr = (sel == 0) ? A_CFG : (sel == 1) ? A_R0 : (sel == 2) ? A_T0 :
                       (sel == 3) ? A_R1 : 8'($urandom);
            cpu_wr = ($urandom % 4) == 0;
            cpu_wdata = 8'($urandom);
            tok_vld = ($urandom % 3) == 0;
            tok_ep = ($urandom % 4 == 0) ? 4'($urandom) : 4'($urandom % 2);
            tok_pid = 2'($urandom); tok_dtog = 1'($urandom);
            tx_done = ($urandom % 6) == 0;
            bus_rst = ($urandom % 40) == 0;
            clr_halt_ep1 = ($urandom % 10) == 0;
            e_s0r = ($urandom % 12) == 0; e_s0t = ($urandom % 12) == 0; e_s1r = ($urandom % 12) == 0;
            cfg_set_vld = ($urandom % 10) == 0; cfg_set_val = 4'($urandom);
            cycle("R9");
        end
        quiet();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule